// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches a bank of general-purpose input pins and records transitions on them. Each pin has its own rising-edge enable and falling-edge enable. When a pin makes a transition whose direction is enabled, the pin's bit in a sticky edge-status register is set. The bit stays set until software writes a one to it. Every pin passes through a two-flop synchroniser before edge detection, so the pins may be fully asynchronous to the clock.

The low pins each drive their own interrupt line, taken directly from the status bit. All remaining pins are ORed together onto one shared interrupt line, which software decodes by reading the status register. A wake-enable mask selects which latched pins raise a wake request. A simple word-addressed register port gives access to the two edge-enable masks, the status register and the wake mask. Reads are combinational, and a write takes effect at the next clock edge.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the rising-enable, falling-enable, status and wake-enable registers all read zero, and irqDirect, irqShared and wakeReq are low.
- R2: A 0-to-1 transition on a pin whose rising enable is set sets that pin's status bit. A 1-to-0 transition on a pin that has only its rising enable set leaves the bit unchanged.
- R3: A 1-to-0 transition on a pin whose falling enable is set sets that pin's status bit.
- R4: A pin with both enables set latches a transition in either direction.
- R5: A write to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every pending bit.
- R6: irqDirect[i] equals status bit i for pins 0 to 10.
- R7: irqShared is high exactly when any status bit from 11 to 27 is set.
- R8: wakeReq is high exactly when some set status bit has its wake-enable bit set.
- R9: Clearing both enables of a pin stops new transitions on that pin from latching. A status bit that is already set stays set until it is cleared.
- R10: If an enabled edge and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set. Other bits cleared by that write still clear.
- R11: The registers sit at byte offsets 0x0 (rising enable), 0x4 (falling enable), 0x8 (status) and 0xC (wake enable). Bits 31 to 28 of every register read as zero, even after ones are written to them.
- R12: A pin transition appears in the status register after the third rising clock edge that follows it. It is not visible after only two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 28 | Asynchronous pin levels |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqDirect | output | 11 | Dedicated interrupt lines for pins 0 to 10 |
| irqShared | output | 1 | Combined interrupt line for pins 11 to 27 |
| wakeReq | output | 1 | Wake request |

## Verification
Two functions can hit the same status bit in one cycle: detecting an edge and clearing the bit by writing a one to it. The bench provokes this by changing a pin and then timing a status write so that it reaches the clock edge where the synchronised edge is latched. The same write also carries a one for a different bit that is already set. The result is correct when the bit with the edge stays set and the other bit clears.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // register word indices (byte offset >> 2)
  localparam logic [1:0] WORD_RISE = 2'd0;
  localparam logic [1:0] WORD_FALL = 2'd1;
  localparam logic [1:0] WORD_STAT = 2'd2;
  localparam logic [1:0] WORD_WAKE = 2'd3;

  typedef struct packed {
    logic       wrRise;
    logic       wrFall;
    logic       wrClr;
    logic       wrWake;
    logic [1:0] rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);
  logic [1:0] wordSel;
  assign wordSel = regAddr[3:2];

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = wordSel;
    strobes.wrRise = regWrEn && (wordSel == WORD_RISE);
    strobes.wrFall = regWrEn && (wordSel == WORD_FALL);
    strobes.wrClr  = regWrEn && (wordSel == WORD_STAT);
    strobes.wrWake = regWrEn && (wordSel == WORD_WAKE);
  end
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT    = 28,
  parameter int DIRECT_COUNT = 11,
  parameter int DATA_W       = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PIN_COUNT-1:0]    pinIn,
  input  ctrlStrobes_t            strobes,
  input  logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       rdData,
  output logic [DIRECT_COUNT-1:0] irqDirect,
  output logic                    irqShared,
  output logic                    wakeReq,
  output logic [PIN_COUNT-1:0]    statusQ,
  output logic [PIN_COUNT-1:0]    edgeHit,
  output logic [PIN_COUNT-1:0]    riseEnQ,
  output logic [PIN_COUNT-1:0]    fallEnQ,
  output logic [PIN_COUNT-1:0]    wakeEnQ
);
  localparam int PAD_W = DATA_W - PIN_COUNT;

  logic [PIN_COUNT-1:0] syncA, syncB, prevQ;
  logic [PIN_COUNT-1:0] wrBits, clrMask;

  assign wrBits  = wrData[PIN_COUNT-1:0];
  assign clrMask = strobes.wrClr ? wrBits : '0;

  // two-flop synchroniser followed by one history flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic roseNow, fellNow;
    assign roseNow    =  syncB[p] && !prevQ[p];
    assign fellNow    = !syncB[p] &&  prevQ[p];
    assign edgeHit[p] = (roseNow && riseEnQ[p]) || (fellNow && fallEnQ[p]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseEnQ <= '0;
      fallEnQ <= '0;
      wakeEnQ <= '0;
      statusQ <= '0;
    end else begin
      if (strobes.wrRise) riseEnQ <= wrBits;
      if (strobes.wrFall) fallEnQ <= wrBits;
      if (strobes.wrWake) wakeEnQ <= wrBits;
      // a fresh edge takes priority over a same-cycle clear
      statusQ <= (statusQ & ~clrMask) | edgeHit;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      WORD_RISE: rdData = {{PAD_W{1'b0}}, riseEnQ};
      WORD_FALL: rdData = {{PAD_W{1'b0}}, fallEnQ};
      WORD_STAT: rdData = {{PAD_W{1'b0}}, statusQ};
      default:   rdData = {{PAD_W{1'b0}}, wakeEnQ};
    endcase
  end

  assign irqDirect = statusQ[DIRECT_COUNT-1:0];
  assign irqShared = |statusQ[PIN_COUNT-1:DIRECT_COUNT];
  assign wakeReq   = |(statusQ & wakeEnQ);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT    = 28,
  parameter int DIRECT_COUNT = 11,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PIN_COUNT-1:0]    pinIn,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  output logic [DATA_W-1:0]       regRdData,
  output logic [DIRECT_COUNT-1:0] irqDirect,
  output logic                    irqShared,
  output logic                    wakeReq
);
  ctrlStrobes_t         strobes;
  logic [PIN_COUNT-1:0] statusQ, edgeHit, riseEnQ, fallEnQ, wakeEnQ;

  gpio_edge_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  gpio_edge_dp #(
    .PIN_COUNT   (PIN_COUNT),
    .DIRECT_COUNT(DIRECT_COUNT),
    .DATA_W      (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .strobes  (strobes),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irqDirect(irqDirect),
    .irqShared(irqShared),
    .wakeReq  (wakeReq),
    .statusQ  (statusQ),
    .edgeHit  (edgeHit),
    .riseEnQ  (riseEnQ),
    .fallEnQ  (fallEnQ),
    .wakeEnQ  (wakeEnQ)
  );
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int PIN_COUNT    = 28,
  parameter int DIRECT_COUNT = 11,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       regAddr,
  input logic [DATA_W-1:0]       regRdData,
  input logic [DIRECT_COUNT-1:0] irqDirect,
  input logic                    irqShared,
  input logic                    wakeReq,
  input logic [PIN_COUNT-1:0]    statusQ,
  input logic [PIN_COUNT-1:0]    edgeHit,
  input logic [PIN_COUNT-1:0]    riseEnQ,
  input logic [PIN_COUNT-1:0]    fallEnQ
);
  AST_DIRECT_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[3:2] == 2'd2) |-> (irqDirect == regRdData[DIRECT_COUNT-1:0])); // R6

  AST_SHARED_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[3:2] == 2'd2) |-> (irqShared == (|regRdData[PIN_COUNT-1:DIRECT_COUNT]))); // R7

  AST_WAKE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ((|irqDirect) || irqShared)); // R8

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ)) & ~($past(riseEnQ) | $past(fallEnQ))) == '0); // R9

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeHit) |=> ((statusQ & $past(edgeHit)) == $past(edgeHit))); // R10

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:PIN_COUNT] == '0); // R11
endmodule

bind gpio_edge_irq gpio_edge_chk #(
  .PIN_COUNT   (PIN_COUNT),
  .DIRECT_COUNT(DIRECT_COUNT),
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regRdData(regRdData),
  .irqDirect(irqDirect),
  .irqShared(irqShared),
  .wakeReq  (wakeReq),
  .statusQ  (statusQ),
  .edgeHit  (edgeHit),
  .riseEnQ  (riseEnQ),
  .fallEnQ  (fallEnQ)
);

// File: tb/gpio_edge_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb_top;
  localparam int PINS = 28;
  localparam logic [31:0] VALID = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [27:0] pinIn = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [10:0] irqDirect;
  logic        irqShared;
  logic        wakeReq;

  always #2 clk = ~clk;  // 250 MHz

  gpio_edge_irq dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqDirect(irqDirect), .irqShared(irqShared), .wakeReq(wakeReq)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 irqDirect, 2 irqShared, 3 wakeReq
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbQ[$];
  event  sampleEv;
  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;

  // bench-side model, built from the requirements
  logic [31:0] mRise = '0, mFall = '0, mWake = '0, mStat = '0;
  logic [27:0] mPins = '0;

  // monitor: pops expected items and compares with outputs
  initial begin
    forever begin
      @(sampleEv);
      while (sbQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          0: act = regRdData;
          1: act = {21'd0, irqDirect};
          2: act = {31'd0, irqShared};
          default: act = {31'd0, wakeReq};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expectItem(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    #0.1;
    ->sampleEv;
    #0.1;
  endtask

  task automatic expectReg(input logic [3:0] addr, input logic [31:0] exp, input string tag);
    regAddr = addr;
    #0.2;
    expectItem(0, exp, tag);
  endtask

  task automatic checkOutputs(input string tag);
    expectReg(4'h8, mStat, {tag, " status"});
    expectItem(1, {21'd0, mStat[10:0]}, {tag, " R6 irqDirect"});
    expectItem(2, {31'd0, |mStat[27:11]}, {tag, " R7 irqShared"});
    expectItem(3, {31'd0, |(mStat & mWake)}, {tag, " R8 wakeReq"});
  endtask

  task automatic regWrite(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    case (addr[3:2])
      2'd0: mRise = data & VALID;
      2'd1: mFall = data & VALID;
      2'd2: mStat = mStat & ~data;
      default: mWake = data & VALID;
    endcase
  endtask

  function automatic logic [31:0] edgesFor(input logic [27:0] oldV, input logic [27:0] newV);
    logic [31:0] r;
    r = {4'd0, (newV & ~oldV)} & mRise;
    r = r | ({4'd0, (~newV & oldV)} & mFall);
    return r;
  endfunction

  task automatic pinSet(input logic [27:0] newV);
    @(negedge clk);
    pinIn = newV;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mStat = mStat | edgesFor(mPins, newV);
    mPins = newV;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectReg(4'h0, 32'h0, "R1 rise reset");
    expectReg(4'h4, 32'h0, "R1 fall reset");
    expectReg(4'hC, 32'h0, "R1 wake reset");
    checkOutputs("R1");

    // R11 upper bits read as zero, offsets reach the right registers
    regWrite(4'h0, 32'hFFFF_FFFF);
    expectReg(4'h0, VALID, "R11 rise high bits");
    expectReg(4'h4, 32'h0, "R11 fall untouched");
    regWrite(4'h0, 32'h0000_1001);   // pins 0 and 12 rising
    regWrite(4'h4, 32'h0000_1002);   // pins 1 and 12 falling
    regWrite(4'hC, 32'h0000_1000);   // pin 12 wakes
    expectReg(4'h0, 32'h0000_1001, "R11 rise offset");
    expectReg(4'h4, 32'h0000_1002, "R11 fall offset");
    expectReg(4'hC, 32'h0000_1000, "R11 wake offset");

    // R12 latency: visible after third edge, not after second
    @(negedge clk);
    pinIn = 28'h1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expectReg(4'h8, 32'h0, "R12 not after two edges");
    @(posedge clk);
    @(negedge clk);
    mStat = mStat | edgesFor(mPins, 28'h1);
    mPins = 28'h1;
    expectReg(4'h8, 32'h1, "R12 after third edge");
    checkOutputs("R2 rising pin0");

    // R2 rising on fall-only pin1 is ignored; R3 falling latches
    pinSet(28'h3);
    checkOutputs("R2 pin1 rise ignored");
    pinSet(28'h1);
    checkOutputs("R3 pin1 fall");
    // R2 falling on rise-only pin0 is ignored
    pinSet(28'h0);
    checkOutputs("R2 pin0 fall ignored");

    // R4 both edges on shared pin 12, R7/R8 shared and wake
    pinSet(28'h1000);
    checkOutputs("R4 pin12 rise");
    regWrite(4'h8, 32'h0000_1000);
    checkOutputs("R5 clear pin12");
    pinSet(28'h0);
    checkOutputs("R4 pin12 fall");

    // R5 write zero changes nothing, all ones clears all
    regWrite(4'h8, 32'h0);
    checkOutputs("R5 write zero");
    regWrite(4'h8, 32'hFFFF_FFFF);
    expectReg(4'h8, 32'h0, "R5 clear all");
    checkOutputs("R5 after clear all");

    // R9 disabling keeps existing bits, stops new ones
    pinSet(28'h1);
    regWrite(4'h0, 32'h0000_1000);
    regWrite(4'h4, 32'h0000_1000);
    expectReg(4'h8, 32'h1, "R9 kept after disable");
    regWrite(4'h8, 32'h1);
    pinSet(28'h0);
    pinSet(28'h1);
    expectReg(4'h8, 32'h0, "R9 no new latch");
    checkOutputs("R9");

    // R10 edge and clear in the same cycle on pin 2; pin 1 set beforehand
    regWrite(4'h4, 32'h0000_1002);
    pinSet(28'h3);
    pinSet(28'h1);           // pin1 falling -> status bit1
    regWrite(4'h0, 32'h0000_1004);
    @(negedge clk);
    pinIn = 28'h5;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h8; regWrData = 32'h0000_0006;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    mStat = (mStat & ~32'h6) | edgesFor(mPins, 28'h5);
    mPins = 28'h5;
    expectReg(4'h8, 32'h0000_0004, "R10 edge wins, other bit cleared");
    checkOutputs("R10");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule